// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Software Refill

This block is a fully associative address translation buffer whose contents are installed only by software. A lookup presents a virtual page number, the current address-space identifier and whether the access is a store. One cycle later the block reports one outcome: a translation with its physical page number and cacheable flag, a plain miss, a match on a half that is not valid, or a write-protection fault. A miss never starts a table walk. The outcome goes back to the requester, which raises an exception so that a software handler can refill the buffer.

Each of the 64 slots maps an aligned pair of neighbouring virtual pages. The tag holds the page number without its lowest bit, and that bit picks one of two independent halves. Each half has its own physical page number, valid bit, dirty bit and no-cache bit. The dirty bit works as a write permission. A slot can be marked global, in which case the address-space identifier is not compared.

The refill port writes either at an explicit slot or at the slot named by a victim counter. The victim counter runs down every cycle and never names a slot below the pinned count, so the low slots keep translations that must not be evicted.

Top module: `tlb_paired`

## Requirements
- R1: After reset every slot is empty (all valid bits clear), so any lookup reports a miss, and `victim_idx` reads 63.
- R2: The outcome of a lookup taken with `lk_req` high appears on the `rs_*` outputs one clock edge later, with `rs_valid` high. In that cycle exactly one of `rs_hit`, `rs_miss`, `rs_inval`, `rs_modfault` is high. When `rs_valid` is low, all `rs_*` outputs are zero.
- R3: A slot matches when its tag equals `lk_vpn[19:1]`. Then `lk_vpn[0]` = 0 selects the low half and `lk_vpn[0]` = 1 selects the high half.
- R4: A slot with its global bit clear matches only when its identifier equals `lk_asid`. A slot with its global bit set matches for any `lk_asid`.
- R5: If several slots match, the one with the lowest index supplies the outcome and `rs_index`, and `rs_multi` is raised. `rs_multi` is low when at most one slot matches.
- R6: If the matching slot's selected half has its valid bit clear, the outcome is `rs_inval` and `rs_ppn` is 0.
- R7: A store to a valid selected half whose dirty bit is clear gives `rs_modfault` with `rs_ppn` = 0. A load to the same half is a hit.
- R8: On a hit, `rs_ppn` and `rs_nocache` come from the selected half and `rs_index` gives the matching slot.
- R9: With `wr_en` high and `wr_rand` low, the slot `wr_index` is overwritten at the clock edge. A lookup in the same cycle still sees the old contents, and lookups from the next cycle on see the new ones.
- R10: `victim_idx` drops by one each cycle while it is above `pin_cnt`. When it is at or below `pin_cnt`, the next value is 63.
- R11: With `wr_en` and `wr_rand` high, the entry is written to the slot that `victim_idx` shows in that cycle, which is never below `pin_cnt` once the counter has settled.
- R12: A slot whose two halves are both invalid takes no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 6 | Current address-space identifier |
| lk_store | input | 1 | Access is a store |
| rs_valid | output | 1 | Lookup outcome present |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No slot matched |
| rs_inval | output | 1 | Matched slot, selected half invalid |
| rs_modfault | output | 1 | Store to a half without write permission |
| rs_multi | output | 1 | More than one slot matched |
| rs_ppn | output | 20 | Physical page number (hit only) |
| rs_nocache | output | 1 | Selected half is uncached (hit only) |
| rs_index | output | 6 | Slot that supplied the outcome |
| wr_en | input | 1 | Install an entry |
| wr_rand | input | 1 | 1: use victim slot, 0: use `wr_index` |
| wr_index | input | 6 | Explicit target slot |
| wr_tag | input | 19 | Pair tag (page number without bit 0) |
| wr_asid | input | 6 | Identifier of the new entry |
| wr_global | input | 1 | Ignore the identifier on match |
| wr_lo_ppn | input | 20 | Low half physical page |
| wr_lo_v | input | 1 | Low half valid |
| wr_lo_d | input | 1 | Low half writable |
| wr_lo_nc | input | 1 | Low half uncached |
| wr_hi_ppn | input | 20 | High half physical page |
| wr_hi_v | input | 1 | High half valid |
| wr_hi_d | input | 1 | High half writable |
| wr_hi_nc | input | 1 | High half uncached |
| pin_cnt | input | 6 | Number of low slots excluded from victim choice |
| victim_idx | output | 6 | Slot a random write would use now |

## Verification
Every lookup outcome is due exactly one clock edge after the request. The bench drives each request on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge, so it reads them half a cycle after they settle. A write becomes visible to lookups issued after the edge that performs it. The bench therefore looks up the slot only once the write strobe has been lowered, except in the one check that probes the same-cycle case on purpose. The victim counter moves on every edge. The bench samples it on each falling edge and predicts the next value from the previous sample and `pin_cnt`. For a random write it uses the value it sampled in the same half-cycle in which it drives the strobe.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W   = 20;
    parameter int ASID_W  = 6;
    parameter int PPN_W   = 20;
    parameter int ENTRIES = 64;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TAG_W  = VPN_W - 1;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             valid;
        logic             dirty;
        logic             nocache;
    } half_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic              global_m;
        half_t             lo;
        half_t             hi;
    } slot_t;

    typedef enum logic [1:0] {
        OUT_MISS  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_INVAL = 2'd2,
        OUT_MOD   = 2'd3
    } outcome_e;

    function automatic half_t pick_half(slot_t s, logic odd);
        return odd ? s.hi : s.lo;
    endfunction
endpackage

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  slot_t             wdata,
    output slot_t             slots [ENTRIES]
);
    slot_t mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign slots = mem_q;

    // R9: a write lands in the addressed slot on the next edge
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  slot_t              slots [ENTRIES],
    input  logic [TAG_W-1:0]   tag,
    input  logic [ASID_W-1:0]  asid,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   first
);
    logic [ENTRIES-1:0] hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = (slots[g].lo.valid || slots[g].hi.valid)
                             && (slots[g].tag == tag)
                             && (slots[g].global_m || slots[g].asid == asid);
        end
    endgenerate

    always_comb begin
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) first = IDX_W'(i);
        end
    end

    assign any   = |hit_vec;
    assign multi = ($countones(hit_vec) > 1);

    // R5: the chosen slot is a matching one whenever any slot matches
    always_comb begin
        if (any) assert_first_matches_R5: assert (hit_vec[first]);
    end
endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] pin,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= TOP;
        else if (cnt_q <= pin) cnt_q <= TOP;
        else                  cnt_q <= cnt_q - 1'b1;
    end

    assign victim = cnt_q;

    assert_step_down_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > pin) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_wrap_top_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= pin) |=> (cnt_q == TOP));
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_req,
    input  logic [19:0] lk_vpn,
    input  logic [5:0]  lk_asid,
    input  logic        lk_store,
    output logic        rs_valid,
    output logic        rs_hit,
    output logic        rs_miss,
    output logic        rs_inval,
    output logic        rs_modfault,
    output logic        rs_multi,
    output logic [19:0] rs_ppn,
    output logic        rs_nocache,
    output logic [5:0]  rs_index,
    input  logic        wr_en,
    input  logic        wr_rand,
    input  logic [5:0]  wr_index,
    input  logic [18:0] wr_tag,
    input  logic [5:0]  wr_asid,
    input  logic        wr_global,
    input  logic [19:0] wr_lo_ppn,
    input  logic        wr_lo_v,
    input  logic        wr_lo_d,
    input  logic        wr_lo_nc,
    input  logic [19:0] wr_hi_ppn,
    input  logic        wr_hi_v,
    input  logic        wr_hi_d,
    input  logic        wr_hi_nc,
    input  logic [5:0]  pin_cnt,
    output logic [5:0]  victim_idx
);
    slot_t            slots [ENTRIES];
    slot_t            wslot;
    logic [IDX_W-1:0] widx, first;
    logic             any, multi;
    outcome_e         outc;
    half_t            sel;

    always_comb begin
        wslot.tag        = wr_tag;
        wslot.asid       = wr_asid;
        wslot.global_m   = wr_global;
        wslot.lo.ppn     = wr_lo_ppn;
        wslot.lo.valid   = wr_lo_v;
        wslot.lo.dirty   = wr_lo_d;
        wslot.lo.nocache = wr_lo_nc;
        wslot.hi.ppn     = wr_hi_ppn;
        wslot.hi.valid   = wr_hi_v;
        wslot.hi.dirty   = wr_hi_d;
        wslot.hi.nocache = wr_hi_nc;
    end

    assign widx = wr_rand ? victim_idx : wr_index;

    tlb_victim_ctr u_victim (
        .clk(clk), .rst(rst), .pin(pin_cnt), .victim(victim_idx)
    );

    tlb_slot_array u_array (
        .clk(clk), .rst(rst), .we(wr_en), .widx(widx),
        .wdata(wslot), .slots(slots)
    );

    tlb_match u_match (
        .slots(slots), .tag(lk_vpn[19:1]), .asid(lk_asid),
        .any(any), .multi(multi), .first(first)
    );

    always_comb begin
        sel = pick_half(slots[first], lk_vpn[0]);
        if (!any)                           outc = OUT_MISS;
        else if (!sel.valid)                outc = OUT_INVAL;
        else if (lk_store && !sel.dirty)    outc = OUT_MOD;
        else                                outc = OUT_HIT;
    end

    always_ff @(posedge clk) begin
        if (rst || !lk_req) begin
            rs_valid    <= 1'b0;
            rs_hit      <= 1'b0;
            rs_miss     <= 1'b0;
            rs_inval    <= 1'b0;
            rs_modfault <= 1'b0;
            rs_multi    <= 1'b0;
            rs_ppn      <= '0;
            rs_nocache  <= 1'b0;
            rs_index    <= '0;
        end else begin
            rs_valid    <= 1'b1;
            rs_hit      <= (outc == OUT_HIT);
            rs_miss     <= (outc == OUT_MISS);
            rs_inval    <= (outc == OUT_INVAL);
            rs_modfault <= (outc == OUT_MOD);
            rs_multi    <= multi;
            rs_ppn      <= (outc == OUT_HIT) ? sel.ppn : '0;
            rs_nocache  <= (outc == OUT_HIT) && sel.nocache;
            rs_index    <= first;
        end
    end

    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> $countones({rs_hit, rs_miss, rs_inval, rs_modfault}) == 1);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rs_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |-> (rs_ppn == '0 && !rs_multi && !rs_hit));
    assert_fault_no_ppn_R7: assert property (@(posedge clk) disable iff (rst)
        (rs_modfault || rs_inval) |-> rs_ppn == '0);
endmodule

// File: tb/tlb_paired_test.sv
module tlb_paired_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst;
    logic        lk_req, lk_store;
    logic [19:0] lk_vpn;
    logic [5:0]  lk_asid;
    logic        rs_valid, rs_hit, rs_miss, rs_inval, rs_modfault, rs_multi, rs_nocache;
    logic [19:0] rs_ppn;
    logic [5:0]  rs_index;
    logic        wr_en, wr_rand, wr_global;
    logic [5:0]  wr_index, wr_asid, pin_cnt, victim_idx;
    logic [18:0] wr_tag;
    logic [19:0] wr_lo_ppn, wr_hi_ppn;
    logic        wr_lo_v, wr_lo_d, wr_lo_nc, wr_hi_v, wr_hi_d, wr_hi_nc;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_paired uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] idx, input bit rnd, input logic [18:0] tag,
                       input logic [5:0] asid, input bit g,
                       input logic [19:0] lp, input bit lv, input bit ld, input bit lnc,
                       input logic [19:0] hp, input bit hv, input bit hd, input bit hnc);
        wr_en = 1; wr_rand = rnd; wr_index = idx; wr_tag = tag; wr_asid = asid; wr_global = g;
        wr_lo_ppn = lp; wr_lo_v = lv; wr_lo_d = ld; wr_lo_nc = lnc;
        wr_hi_ppn = hp; wr_hi_v = hv; wr_hi_d = hd; wr_hi_nc = hnc;
        @(posedge clk); @(negedge clk);
        wr_en = 0; wr_rand = 0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [5:0] asid, input bit st);
        lk_req = 1; lk_vpn = vpn; lk_asid = asid; lk_store = st;
        @(posedge clk); @(negedge clk);
        lk_req = 0;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] ppn, input bit nc, input logic [5:0] idx);
        chk(rs_valid && rs_hit, req, {rs_valid, rs_hit}, 2'b11);
        chk(rs_ppn == ppn, req, rs_ppn, ppn);
        chk(rs_nocache == nc, req, rs_nocache, nc);
        chk(rs_index == idx, req, rs_index, idx);
    endtask

    task automatic t_reset;
        chk(victim_idx == 6'd63, "R1 victim after reset", victim_idx, 63);
        chk(!rs_valid && rs_ppn == 0 && !rs_hit, "R2 idle outputs", {rs_valid, rs_hit, rs_ppn}, 0);
        look(20'h00000, 6'd0, 1'b0);
        chk(rs_valid && rs_miss, "R1 R12 empty lookup miss", {rs_valid, rs_miss}, 2'b11);
        chk(!rs_multi, "R12 empty slots no multi", rs_multi, 0);
        @(negedge clk);
        chk(!rs_valid && !rs_miss, "R2 result lasts one cycle", {rs_valid, rs_miss}, 0);
    endtask

    task automatic t_pair;
        put(6'd5, 0, 19'h0ABCD, 6'd3, 0, 20'h11111, 1, 1, 0, 20'h22222, 1, 1, 1);
        look({19'h0ABCD, 1'b0}, 6'd3, 1'b0);
        expect_hit("R3 R8 R9 low half", 20'h11111, 0, 6'd5);
        chk(!rs_multi, "R5 single match", rs_multi, 0);
        look({19'h0ABCD, 1'b1}, 6'd3, 1'b1);
        expect_hit("R3 R8 high half", 20'h22222, 1, 6'd5);
    endtask

    task automatic t_asid;
        look({19'h0ABCD, 1'b0}, 6'd4, 1'b0);
        chk(rs_miss, "R4 other id misses", rs_miss, 1);
        put(6'd6, 0, 19'h00777, 6'd9, 1, 20'h33333, 1, 1, 0, 20'h44444, 1, 1, 0);
        look({19'h00777, 1'b1}, 6'd1, 1'b0);
        expect_hit("R4 global ignores id", 20'h44444, 0, 6'd6);
    endtask

    task automatic t_inval_mod;
        put(6'd7, 0, 19'h00100, 6'd2, 0, 20'h55555, 1, 0, 0, 20'h66666, 0, 1, 0);
        look({19'h00100, 1'b1}, 6'd2, 1'b0);
        chk(rs_inval && rs_ppn == 0, "R6 invalid half", {rs_inval, rs_ppn}, {1'b1, 20'h0});
        look({19'h00100, 1'b0}, 6'd2, 1'b1);
        chk(rs_modfault && !rs_hit && rs_ppn == 0, "R7 store to clean half",
            {rs_modfault, rs_hit, rs_ppn}, {2'b10, 20'h0});
        look({19'h00100, 1'b0}, 6'd2, 1'b0);
        expect_hit("R7 load to clean half", 20'h55555, 0, 6'd7);
    endtask

    task automatic t_multi_and_timing;
        put(6'd20, 0, 19'h00200, 6'd2, 0, 20'h0BBBB, 1, 1, 0, 20'h0, 0, 0, 0);
        put(6'd10, 0, 19'h00200, 6'd2, 0, 20'h0AAAA, 1, 1, 0, 20'h0, 0, 0, 0);
        look({19'h00200, 1'b0}, 6'd2, 1'b0);
        expect_hit("R5 lowest index wins", 20'h0AAAA, 0, 6'd10);
        chk(rs_multi, "R5 multi flag", rs_multi, 1);
        put(6'd10, 0, 19'h00200, 6'd2, 0, 20'h0, 0, 0, 0, 20'h0, 0, 0, 0);
        look({19'h00200, 1'b0}, 6'd2, 1'b0);
        expect_hit("R12 emptied slot skipped", 20'h0BBBB, 0, 6'd20);
        chk(!rs_multi, "R12 no multi after empty", rs_multi, 0);
        // same-cycle write and lookup
        lk_req = 1; lk_vpn = {19'h00300, 1'b0}; lk_asid = 6'd2; lk_store = 0;
        put(6'd30, 0, 19'h00300, 6'd2, 0, 20'h0CCCC, 1, 1, 0, 20'h0, 0, 0, 0);
        lk_req = 0;
        chk(rs_miss, "R9 same-cycle sees old", rs_miss, 1);
        look({19'h00300, 1'b0}, 6'd2, 1'b0);
        expect_hit("R9 next cycle sees new", 20'h0CCCC, 0, 6'd30);
    endtask

    task automatic t_victim;
        logic [5:0] prev, exp_v, v;
        pin_cnt = 6'd60;
        @(negedge clk);
        prev = victim_idx;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            exp_v = (prev <= 6'd60) ? 6'd63 : prev - 1'b1;
            chk(victim_idx == exp_v, "R10 victim sequence", victim_idx, exp_v);
            chk(victim_idx >= 6'd60, "R11 victim above pinned", victim_idx, 60);
            prev = victim_idx;
        end
        v = victim_idx;
        put(6'd0, 1, 19'h00400, 6'd1, 0, 20'h0DDDD, 1, 1, 0, 20'h0, 0, 0, 0);
        look({19'h00400, 1'b0}, 6'd1, 1'b0);
        expect_hit("R11 random write slot", 20'h0DDDD, 0, v);
        look({19'h0ABCD, 1'b0}, 6'd3, 1'b0);
        expect_hit("R11 pinned slot kept", 20'h11111, 0, 6'd5);
    endtask

    initial begin
        rst = 1; lk_req = 0; lk_vpn = 0; lk_asid = 0; lk_store = 0;
        wr_en = 0; wr_rand = 0; wr_index = 0; wr_tag = 0; wr_asid = 0; wr_global = 0;
        wr_lo_ppn = 0; wr_lo_v = 0; wr_lo_d = 0; wr_lo_nc = 0;
        wr_hi_ppn = 0; wr_hi_v = 0; wr_hi_d = 0; wr_hi_nc = 0; pin_cnt = 6'd8;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_pair();
        t_asid();
        t_inval_mod();
        t_multi_and_timing();
        t_victim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule